// File: doc/BRIEF.md
# Channel Sample Conditioning Chain

This block conditions the sample stream of one detector readout channel. Each accepted 10-bit converter sample passes through a fixed sequence of registered stages. The first stage optionally inverts the sample so that pulses of either sign become positive, then removes a programmable pedestal, clamping at zero. The second stage is a first-order filter that cancels the long decaying tail following each pulse. The third stage subtracts a slowly tracking baseline estimate that follows low-frequency drift and is held still while a pulse is present. The last stage keeps only samples near signal activity, and labels each one with its position in the input stream.

All configuration arrives on plain input pins and is expected to be static while samples flow. Samples arrive with a valid strobe at up to one per clock. An output sample is released only once the sample after it has been seen, because whether a sample is kept depends on its successor.

Top module: `chan_dsp_chain`

## Requirements
- R1: With `cfg_invert` = 1 the working value is the bitwise complement of the sample (1023 − raw); with 0 it is the raw sample.
- R2: The first stage outputs working value minus `cfg_offset` when the working value is larger, and 0 otherwise.
- R3: The filter outputs y[n] = s[n] − floor(cfg_tail_k · s[n−1] / 256), where s[n−1] is the previous accepted first-stage value (0 after reset).
- R4: The corrected value is c[n] = y[n] − floor(A / 2^AVG_LOG2), where the accumulator A starts at 0 and gains c[n] after every sample that is not above threshold.
- R5: A sample is above threshold when c[n], taken as signed, is greater than `cfg_thresh` (unsigned, 11 bits).
- R6: Sample n is emitted exactly when sample n, n−1 or n+1 is above threshold; each kept sample is emitted once, in order, with `out_sample` = c[n].
- R7: `out_idx` is the count of samples accepted since reset before sample n, modulo 2^IDX_W, starting at 0.
- R8: While `rst_n` is low at a clock edge, the next cycle shows `out_valid` = 0 and `out_idx` = 0, whatever the inputs.
- R9: Cycles with `in_valid` = 0 change no state; inserting idle cycles leaves the emitted values and indices unchanged.
- R10: The emission of sample n is visible in the cycle after the third clock edge that follows the edge accepting sample n+1.
- R11: During a pulse the baseline does not move, so a long flat pulse stays above threshold for its whole length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A sample is present this cycle |
| in_sample | input | 10 | Raw converter sample |
| cfg_invert | input | 1 | Complement samples before processing |
| cfg_offset | input | 10 | Pedestal removed in the first stage |
| cfg_tail_k | input | 8 | Tail coefficient, in units of 1/256 |
| cfg_thresh | input | 11 | Suppression threshold |
| out_valid | output | 1 | One kept sample is presented this cycle |
| out_sample | output | 12 | Corrected signed sample value |
| out_idx | output | 8 | Stream index of the presented sample |

## Verification
The suppression window and the baseline freeze meet on the same sample: the threshold decision that selects a sample for output is also the one that stops the accumulator, so an error in either shows as a wrong emitted set. The bench provokes this with a slow ramp followed by a long flat pulse and with clusters separated by one quiet sample, where a neighbour is emitted only because of the sample beside it. Results are judged against a reference computed in the bench from the stated arithmetic, comparing every emitted value and index, with a repeat of the same stream interleaved with idle cycles.

// File: rtl/chan_dsp_pkg.sv
// Shared definitions for the channel conditioning chain.
// Assumes nothing beyond standard SystemVerilog packages.
package chan_dsp_pkg;
    typedef enum logic {
        POL_DIRECT = 1'b0,
        POL_INVERT = 1'b1
    } polarity_e;

    localparam int DEF_ADC_W    = 10;
    localparam int DEF_K_W      = 8;
    localparam int DEF_IDX_W    = 16;
    localparam int DEF_AVG_LOG2 = 3;
endpackage

// File: rtl/cdsp_front.sv
// Front stage: polarity choice, pedestal removal with clamp at zero,
// and the stream index counter.
// Assumes cfg_offset is static while samples flow.
module cdsp_front
    import chan_dsp_pkg::*;
#(
    parameter int ADC_W = DEF_ADC_W,
    parameter int IDX_W = DEF_IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [ADC_W-1:0] in_sample,
    input  logic             cfg_invert,
    input  logic [ADC_W-1:0] cfg_offset,
    output logic             s1_valid,
    output logic [ADC_W-1:0] s1_val,
    output logic [IDX_W-1:0] s1_idx
);
    polarity_e        pol;
    logic [ADC_W-1:0] work;
    logic [ADC_W-1:0] diff;
    logic             over;
    logic [IDX_W-1:0] cnt_q;

    // Pick the working value and compare it with the pedestal.
    always_comb begin
        pol  = polarity_e'(cfg_invert);
        work = (pol == POL_INVERT) ? ~in_sample : in_sample;
        over = work > cfg_offset;
        diff = work - cfg_offset;
    end

    // Register the clamped value and tag it with the running index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_val   <= '0;
            s1_idx   <= '0;
            cnt_q    <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_val <= over ? diff : '0;
                s1_idx <= cnt_q;
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cdsp_tail_shaper.sv
// First-order tail cancellation: y = s[n] - floor(k * s[n-1] / 2^K_W).
// Assumes k < 2^K_W so the subtracted term never exceeds s[n-1].
module cdsp_tail_shaper #(
    parameter int ADC_W = 10,
    parameter int K_W   = 8,
    parameter int IDX_W = 16,
    parameter int SW    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s1_valid,
    input  logic [ADC_W-1:0]     s1_val,
    input  logic [IDX_W-1:0]     s1_idx,
    input  logic [K_W-1:0]       cfg_tail_k,
    output logic                 sh_valid,
    output logic signed [SW-1:0] sh_y,
    output logic [IDX_W-1:0]     sh_idx
);
    localparam int PW = ADC_W + K_W;

    logic [ADC_W-1:0]     prev_q;
    logic [PW-1:0]        prod;
    logic [ADC_W-1:0]     tail;
    logic signed [SW-1:0] y_next;

    // Scale the previous value and subtract it from the current one.
    always_comb begin
        prod   = PW'(cfg_tail_k) * PW'(prev_q);
        tail   = prod[PW-1:K_W];
        y_next = signed'({{(SW-ADC_W){1'b0}}, s1_val})
               - signed'({{(SW-ADC_W){1'b0}}, tail});
    end

    // Register the filtered value and remember the current input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_valid <= 1'b0;
            sh_y     <= '0;
            sh_idx   <= '0;
            prev_q   <= '0;
        end else begin
            sh_valid <= s1_valid;
            if (s1_valid) begin
                sh_y   <= y_next;
                sh_idx <= s1_idx;
                prev_q <= s1_val;
            end
        end
    end
endmodule

// File: rtl/cdsp_drift_baseline.sv
// Adaptive baseline: an exponential running mean of the filtered value,
// subtracted from each sample and frozen while the sample is above threshold.
// Assumes the corrected value fits in SW signed bits.
module cdsp_drift_baseline #(
    parameter int IDX_W    = 16,
    parameter int SW       = 12,
    parameter int AVG_LOG2 = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sh_valid,
    input  logic signed [SW-1:0] sh_y,
    input  logic [IDX_W-1:0]     sh_idx,
    input  logic [SW-2:0]        cfg_thresh,
    output logic                 cv_valid,
    output logic signed [SW-1:0] cv_val,
    output logic                 cv_above,
    output logic [IDX_W-1:0]     cv_idx
);
    localparam int AW = SW + AVG_LOG2 + 1;

    logic signed [AW-1:0] acc_q;
    logic signed [AW-1:0] base_full;
    logic signed [SW-1:0] base;
    logic signed [SW-1:0] corr;
    logic signed [SW-1:0] thr_s;
    logic                 above;
    logic signed [AW-1:0] acc_next;

    // Derive the baseline, the corrected value and the threshold decision.
    always_comb begin
        base_full = acc_q >>> AVG_LOG2;
        base      = base_full[SW-1:0];
        corr      = sh_y - base;
        thr_s     = signed'({1'b0, cfg_thresh});
        above     = corr > thr_s;
        acc_next  = acc_q + signed'({{(AW-SW){corr[SW-1]}}, corr});
    end

    // Register the corrected sample; update the mean only on quiet samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cv_valid <= 1'b0;
            cv_val   <= '0;
            cv_above <= 1'b0;
            cv_idx   <= '0;
            acc_q    <= '0;
        end else begin
            cv_valid <= sh_valid;
            if (sh_valid) begin
                cv_val   <= corr;
                cv_above <= above;
                cv_idx   <= sh_idx;
                if (!above) begin
                    acc_q <= acc_next;
                end
            end
        end
    end
endmodule

// File: rtl/cdsp_zero_supp.sv
// Zero suppression with a one-sample guard on each side of every cluster.
// Holds one sample back: it is released when its successor arrives.
// Assumes the above-threshold flag travels with each corrected value.
module cdsp_zero_supp #(
    parameter int IDX_W = 16,
    parameter int SW    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cv_valid,
    input  logic signed [SW-1:0] cv_val,
    input  logic                 cv_above,
    input  logic [IDX_W-1:0]     cv_idx,
    output logic                 out_valid,
    output logic signed [SW-1:0] out_sample,
    output logic [IDX_W-1:0]     out_idx
);
    logic                 held_full;
    logic signed [SW-1:0] held_val;
    logic [IDX_W-1:0]     held_idx;
    logic                 held_above;
    logic                 before_above;
    logic                 keep;

    // Keep the held sample if it or either neighbour is above threshold.
    always_comb begin
        keep = held_full && (held_above || before_above || cv_above);
    end

    // Release the held sample and shift the window on every new sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_sample   <= '0;
            out_idx      <= '0;
            held_full    <= 1'b0;
            held_val     <= '0;
            held_idx     <= '0;
            held_above   <= 1'b0;
            before_above <= 1'b0;
        end else if (cv_valid) begin
            out_valid    <= keep;
            out_sample   <= held_val;
            out_idx      <= held_idx;
            before_above <= held_above;
            held_full    <= 1'b1;
            held_val     <= cv_val;
            held_idx     <= cv_idx;
            held_above   <= cv_above;
        end else begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/chan_dsp_chain.sv
// Top of the channel conditioning chain: front stage, tail shaper,
// drift baseline and zero suppression in a fixed order.
// Assumes static configuration while samples flow.
module chan_dsp_chain
    import chan_dsp_pkg::*;
#(
    parameter int ADC_W    = DEF_ADC_W,
    parameter int K_W      = DEF_K_W,
    parameter int IDX_W    = 8,
    parameter int AVG_LOG2 = DEF_AVG_LOG2,
    localparam int SW      = ADC_W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [ADC_W-1:0]     in_sample,
    input  logic                 cfg_invert,
    input  logic [ADC_W-1:0]     cfg_offset,
    input  logic [K_W-1:0]       cfg_tail_k,
    input  logic [SW-2:0]        cfg_thresh,
    output logic                 out_valid,
    output logic signed [SW-1:0] out_sample,
    output logic [IDX_W-1:0]     out_idx
);
    logic                 s1_valid;
    logic [ADC_W-1:0]     s1_val;
    logic [IDX_W-1:0]     s1_idx;
    logic                 sh_valid;
    logic signed [SW-1:0] sh_y;
    logic [IDX_W-1:0]     sh_idx;
    logic                 cv_valid;
    logic signed [SW-1:0] cv_val;
    logic                 cv_above;
    logic [IDX_W-1:0]     cv_idx;

    cdsp_front #(.ADC_W(ADC_W), .IDX_W(IDX_W)) u_front (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .cfg_invert(cfg_invert), .cfg_offset(cfg_offset),
        .s1_valid(s1_valid), .s1_val(s1_val), .s1_idx(s1_idx)
    );

    cdsp_tail_shaper #(.ADC_W(ADC_W), .K_W(K_W), .IDX_W(IDX_W), .SW(SW)) u_shaper (
        .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_val(s1_val),
        .s1_idx(s1_idx), .cfg_tail_k(cfg_tail_k),
        .sh_valid(sh_valid), .sh_y(sh_y), .sh_idx(sh_idx)
    );

    cdsp_drift_baseline #(.IDX_W(IDX_W), .SW(SW), .AVG_LOG2(AVG_LOG2)) u_base (
        .clk(clk), .rst_n(rst_n), .sh_valid(sh_valid), .sh_y(sh_y),
        .sh_idx(sh_idx), .cfg_thresh(cfg_thresh),
        .cv_valid(cv_valid), .cv_val(cv_val), .cv_above(cv_above), .cv_idx(cv_idx)
    );

    cdsp_zero_supp #(.IDX_W(IDX_W), .SW(SW)) u_zs (
        .clk(clk), .rst_n(rst_n), .cv_valid(cv_valid), .cv_val(cv_val),
        .cv_above(cv_above), .cv_idx(cv_idx),
        .out_valid(out_valid), .out_sample(out_sample), .out_idx(out_idx)
    );
endmodule

// File: rtl/chan_dsp_chain_checker.sv
// Temporal checks on the conditioning chain, attached by bind.
// Assumes static configuration while samples flow.
module chan_dsp_chain_checker #(
    parameter int ADC_W = 10,
    parameter int IDX_W = 8,
    parameter int SW    = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 out_valid,
    input logic [IDX_W-1:0]     out_idx,
    input logic                 s1_valid,
    input logic [ADC_W-1:0]     s1_val,
    input logic [ADC_W-1:0]     cfg_offset,
    input logic                 sh_valid,
    input logic signed [SW-1:0] sh_y
);
    logic             seen_q;
    logic [IDX_W-1:0] last_idx_q;

    // Remember the index of the most recent emission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q     <= 1'b0;
            last_idx_q <= '0;
        end else if (out_valid) begin
            seen_q     <= 1'b1;
            last_idx_q <= out_idx;
        end
    end

    // R8: reset clears the output side.
    p_reset_quiet_r8: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_idx == '0));

    // R10: every emission follows an accepted sample four edges earlier.
    p_emit_after_input_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 4));

    // R2: clamped value plus pedestal never exceeds full scale.
    p_pedestal_clamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> ({1'b0, s1_val} + {1'b0, $past(cfg_offset)}) <= (ADC_W+1)'(2**ADC_W - 1));

    // R3: the tail term only ever lowers the value.
    p_shaper_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sh_valid |-> sh_y <= signed'({2'b00, $past(s1_val)}));

    // R7: successive emissions carry distinct indices.
    p_idx_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && seen_q) |-> out_idx != last_idx_q);
endmodule

bind chan_dsp_chain chan_dsp_chain_checker #(
    .ADC_W(ADC_W), .IDX_W(IDX_W), .SW(SW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
    .out_idx(out_idx), .s1_valid(s1_valid), .s1_val(s1_val),
    .cfg_offset(cfg_offset), .sh_valid(sh_valid), .sh_y(sh_y)
);

// File: tb/chan_dsp_chain_bench.sv
// Directed bench for the conditioning chain; one task per scenario.
module chan_dsp_chain_bench;
    localparam int ADC_W = 10;
    localparam int K_W   = 8;
    localparam int IDX_W = 8;
    localparam int AVG   = 3;
    localparam int SW    = ADC_W + 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic [ADC_W-1:0]     in_sample = '0;
    logic                 cfg_invert = 1'b0;
    logic [ADC_W-1:0]     cfg_offset = '0;
    logic [K_W-1:0]       cfg_tail_k = '0;
    logic [SW-2:0]        cfg_thresh = '0;
    logic                 out_valid;
    logic signed [SW-1:0] out_sample;
    logic [IDX_W-1:0]     out_idx;

    chan_dsp_chain #(.ADC_W(ADC_W), .K_W(K_W), .IDX_W(IDX_W), .AVG_LOG2(AVG)) u_chan_dsp_chain (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .cfg_invert(cfg_invert), .cfg_offset(cfg_offset), .cfg_tail_k(cfg_tail_k),
        .cfg_thresh(cfg_thresh), .out_valid(out_valid), .out_sample(out_sample),
        .out_idx(out_idx)
    );

    always #10 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 0;

    int stim [0:511];
    int acc_cyc [0:511];
    int got_s [$];
    int got_i [$];
    int got_c [$];
    int exp_s [$];
    int exp_i [$];

    always @(posedge clk) cyc <= cyc + 1;

    // Collect emitted samples away from the active edge.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            got_s.push_back(int'(out_sample));
            got_i.push_back(int'(out_idx));
            got_c.push_back(cyc);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b1;
        in_sample = 10'h3FF;
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b1;
        got_s.delete(); got_i.delete(); got_c.delete();
    endtask

    // Reference arithmetic from R1..R6 and R7.
    task automatic build_model(input int n);
        int s1 [0:511];
        int cv [0:511];
        bit ab [0:511];
        int prev, acc, base, w;
        exp_s.delete(); exp_i.delete();
        prev = 0; acc = 0;
        for (int i = 0; i < n; i++) begin
            w = cfg_invert ? 1023 - stim[i] : stim[i];
            s1[i] = (w > int'(cfg_offset)) ? w - int'(cfg_offset) : 0;
            base = acc >>> AVG;
            cv[i] = s1[i] - ((int'(cfg_tail_k) * prev) >>> 8) - base;
            ab[i] = cv[i] > int'(cfg_thresh);
            if (!ab[i]) acc = acc + cv[i];
            prev = s1[i];
        end
        for (int i = 0; i < n - 1; i++) begin
            if (ab[i] || ab[i+1] || (i > 0 && ab[i-1])) begin
                exp_s.push_back(cv[i]);
                exp_i.push_back(i % (1 << IDX_W));
            end
        end
    endtask

    // Drive n samples, optionally with idle cycles, then compare the stream.
    task automatic drive_and_compare(input int n, input bit gaps, input string req);
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 3 == 1)) begin
                in_valid = 1'b0;
                repeat (2) @(negedge clk);
            end
            in_valid = 1'b1;
            in_sample = stim[i][ADC_W-1:0];
            acc_cyc[i] = cyc + 1;
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (8) @(negedge clk);
        build_model(n);
        chk(got_s.size() == exp_s.size(), {req, " count"}, got_s.size(), exp_s.size());
        for (int k = 0; k < exp_s.size() && k < got_s.size(); k++) begin
            chk(got_s[k] == exp_s[k], {req, " value"}, got_s[k], exp_s[k]);
            chk(got_i[k] == exp_i[k], {req, " index R7"}, got_i[k], exp_i[k]);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b1; in_sample = 10'h3FF;
        cfg_thresh = '0;
        repeat (5) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R8 out_valid in reset", out_valid, 0);
            chk(out_idx == '0, "R8 out_idx in reset", out_idx, 0);
        end
        in_valid = 1'b0; rst_n = 1'b1;
    endtask

    task automatic t_positive();
        do_reset();
        cfg_invert = 0; cfg_offset = 200; cfg_tail_k = 0; cfg_thresh = 100;
        for (int i = 0; i < 30; i++) stim[i] = 200;
        stim[10] = 600; stim[11] = 800; stim[12] = 500; stim[13] = 250;
        drive_and_compare(30, 0, "R2 R5 R6 positive pulse");
        chk(got_i.size() > 0 && got_i[0] == 9, "R6 pre-sample index", got_i.size() > 0 ? got_i[0] : -1, 9);
        if (got_c.size() > 0)
            chk(got_c[0] == acc_cyc[10] + 3, "R10 latency", got_c[0], acc_cyc[10] + 3);
    endtask

    task automatic t_negative();
        do_reset();
        cfg_invert = 1; cfg_offset = 200; cfg_tail_k = 0; cfg_thresh = 100;
        for (int i = 0; i < 30; i++) stim[i] = 823;
        stim[8] = 423; stim[9] = 223; stim[10] = 523;
        drive_and_compare(30, 0, "R1 inverted polarity");
    endtask

    task automatic t_tail();
        do_reset();
        cfg_invert = 0; cfg_offset = 200; cfg_tail_k = 128; cfg_thresh = 30;
        for (int i = 0; i < 30; i++) stim[i] = 200;
        stim[5] = 840; stim[6] = 520; stim[7] = 360; stim[8] = 280;
        stim[9] = 240; stim[10] = 220; stim[11] = 210;
        drive_and_compare(30, 0, "R3 tail cancellation");
        chk(got_s.size() == 3, "R3 only pulse and guards kept", got_s.size(), 3);
    endtask

    task automatic t_drift();
        do_reset();
        cfg_invert = 0; cfg_offset = 100; cfg_tail_k = 0; cfg_thresh = 20;
        for (int i = 0; i < 200; i++) stim[i] = 100 + i;
        for (int i = 200; i < 260; i++) stim[i] = 300;
        for (int i = 220; i < 240; i++) stim[i] = 600;
        drive_and_compare(260, 0, "R4 R11 drift and frozen baseline");
    endtask

    task automatic t_gaps();
        do_reset();
        cfg_invert = 0; cfg_offset = 200; cfg_tail_k = 64; cfg_thresh = 80;
        for (int i = 0; i < 40; i++) stim[i] = 200 + (i % 4);
        stim[12] = 700; stim[13] = 650; stim[25] = 500;
        drive_and_compare(40, 1, "R9 idle cycles ignored");
    endtask

    task automatic t_clusters();
        do_reset();
        cfg_invert = 0; cfg_offset = 100; cfg_tail_k = 0; cfg_thresh = 100;
        for (int i = 0; i < 20; i++) stim[i] = 100;
        stim[3] = 400; stim[5] = 400; stim[6] = 400; stim[9] = 400;
        drive_and_compare(20, 0, "R6 adjacent clusters");
    endtask

    task automatic t_wrap();
        do_reset();
        cfg_invert = 0; cfg_offset = 150; cfg_tail_k = 0; cfg_thresh = 100;
        for (int i = 0; i < 300; i++) stim[i] = (i % 20 == 7) ? 550 : 150;
        drive_and_compare(300, 0, "R7 index wrap");
    endtask

    initial begin
        t_reset();
        t_positive();
        t_negative();
        t_tail();
        t_drift();
        t_gaps();
        t_clusters();
        t_wrap();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule